// File: doc/BRIEF.md
# Priority Ordered Pending Interrupt List

This block keeps the set of interrupt sources that are currently asserting, stored as a short list sorted by priority. The lowest slot holds the weakest entry and the highest occupied slot holds the strongest. Each source number maps to a fixed priority and a fixed vector code through two parameter tables, so the list stores only source numbers. The CPU side reads the priority and code of the strongest entry continuously from `pend_prio` and `pend_code`.

The sources are level-triggered. A raise adds a source. A clear removes one named source and closes the gap it leaves. An accept reports the code of the strongest entry one cycle later and does not remove it. The entry stays until its source is cleared explicitly. One raise, one clear and one accept can be presented in the same cycle.

Occupancy is tracked by a three-state machine. `ST_EMPTY` moves to `ST_PARTIAL` on an accepted raise. `ST_PARTIAL` moves to `ST_FULL` when a raise fills the last slot. `ST_PARTIAL` moves back to `ST_EMPTY` when a clear removes the only entry. `ST_FULL` moves to `ST_PARTIAL` on any successful clear. Every other combination holds the state.

Top module: `pend_list`

## Requirements
- R1: After reset the list is empty. `pend_prio` and `pend_code` read 0, and `accept_vld` and `accept_err` are low.
- R2: A raise of a source that is not yet pending inserts it so that the list stays in ascending priority order. After that edge, `pend_prio` and `pend_code` show the priority and code of the highest-priority pending source.
- R3: Among entries of equal priority, the most recently raised one sits above the older ones. When several equal-priority entries are strongest, the newest one is reported.
- R4: A raise of a source that is already pending is ignored. The list order and the reported top entry do not change, even when the list is full.
- R5: A clear of a pending source removes that single entry, searching from the top slot downward, and shifts every entry above it down by one. The edge after the clear, `pend_prio` and `pend_code` show the new top entry, or 0 and 0 if the list is now empty.
- R6: A clear of a source that is not pending has no effect on the list or on the outputs.
- R7: An accept request sampled at an edge produces, one cycle later, `accept_vld` high and `accept_code` equal to the code of the top entry as it stood before that edge. The accept removes nothing.
- R8: An accept while the list is empty produces `accept_vld` high, `accept_code` equal to 0, and a one-cycle `accept_err` pulse. `accept_err` stays low for an accept on a non-empty list.
- R9: When a raise and a clear arrive in the same cycle, the clear is carried out and the raise is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_vld | input | 1 | Raise strobe for `raise_id` |
| raise_id | input | ID_W (3) | Source number to raise |
| clear_vld | input | 1 | Clear strobe for `clear_id` |
| clear_id | input | ID_W (3) | Source number to clear |
| accept_req | input | 1 | Accept request from the CPU |
| pend_prio | output | PRIO_W (4) | Priority of the top entry, 0 when empty |
| pend_code | output | CODE_W (12) | Vector code of the top entry, 0 when empty |
| accept_vld | output | 1 | Registered response to `accept_req` |
| accept_code | output | CODE_W (12) | Code returned by the accept, 0 when the list was empty |
| accept_err | output | 1 | Pulse: an accept found the list empty |

## Verification
The assertions assume that `raise_id` and `clear_id` are known and below `NUM_SRC` whenever their strobes are high. The default eight sources fill the 3-bit field exactly, and the stimulus draws identifiers only from that range. The default priority and code tables contain no zero, so a reported 0 always means the list is empty. The stimulus covers directed cases for tie ordering, duplicate raises on a full list, clears of absent sources and simultaneous raise and clear, followed by a pseudo-random stream of mixed operations. Every clock cycle, the outputs are compared against a queue-based model.

// File: rtl/pend_list_pkg.sv
package pend_list_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } list_state_e;

endpackage

// File: rtl/pend_scan.sv
module pend_scan #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3,
    parameter int CNT_W   = 4,
    parameter int PRIO_W  = 4,
    parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = '0
) (
    input  logic [NUM_SRC-1:0][ID_W-1:0] slot_id,
    input  logic [CNT_W-1:0]             fill,
    input  logic [ID_W-1:0]              raise_id,
    input  logic [ID_W-1:0]              clear_id,
    output logic                         raise_dup,
    output logic                         clear_hit,
    output logic [CNT_W-1:0]             clear_idx,
    output logic [CNT_W-1:0]             ins_idx,
    output logic [ID_W-1:0]              top_id
);

    function automatic logic [PRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
        return SRC_PRIO[int'(id)*PRIO_W +: PRIO_W];
    endfunction

    logic [PRIO_W-1:0] new_prio;
    assign new_prio = prio_of(raise_id);

    // Ascending loop: the last match seen is the highest slot, i.e. the top-down first hit.
    always_comb begin
        raise_dup = 1'b0;
        clear_hit = 1'b0;
        clear_idx = '0;
        ins_idx   = '0;
        top_id    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (CNT_W'(i) < fill) begin
                if (slot_id[i] == raise_id) begin
                    raise_dup = 1'b1;
                end
                if (slot_id[i] == clear_id) begin
                    clear_hit = 1'b1;
                    clear_idx = CNT_W'(i);
                end
                if (prio_of(slot_id[i]) <= new_prio) begin
                    ins_idx = ins_idx + CNT_W'(1);
                end
                if (CNT_W'(i) + CNT_W'(1) == fill) begin
                    top_id = slot_id[i];
                end
            end
        end
    end

endmodule

// File: rtl/pend_slots.sv
module pend_slots #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3,
    parameter int CNT_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         do_ins,
    input  logic [CNT_W-1:0]             ins_idx,
    input  logic [ID_W-1:0]              ins_id,
    input  logic                         do_del,
    input  logic [CNT_W-1:0]             del_idx,
    output logic [NUM_SRC-1:0][ID_W-1:0] slot_q
);

    logic [NUM_SRC-1:0][ID_W-1:0] slot_nxt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        logic [ID_W-1:0] above;
        logic [ID_W-1:0] below;

        if (g == NUM_SRC - 1) begin : g_top
            assign above = '0;
        end else begin : g_inner_hi
            assign above = slot_q[g+1];
        end

        if (g == 0) begin : g_bottom
            assign below = '0;
        end else begin : g_inner_lo
            assign below = slot_q[g-1];
        end

        // Removal pulls the upper part down; insertion pushes it up.
        assign slot_nxt[g] =
            do_del ? ((CNT_W'(g) >= del_idx) ? above : slot_q[g]) :
            do_ins ? ((CNT_W'(g) >  ins_idx) ? below :
                      (CNT_W'(g) == ins_idx) ? ins_id : slot_q[g]) :
                     slot_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_nxt;
        end
    end

endmodule

// File: rtl/pend_list.sv
module pend_list #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 4,
    parameter int CODE_W  = 12,
    parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO =
        {4'h5, 4'h7, 4'hF, 4'h1, 4'hA, 4'h7, 4'h7, 4'h3},
    parameter logic [NUM_SRC*CODE_W-1:0] SRC_CODE =
        {12'h2E0, 12'h2C0, 12'h2A0, 12'h280, 12'h260, 12'h240, 12'h220, 12'h200},
    localparam int ID_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W = $clog2(NUM_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_vld,
    input  logic [ID_W-1:0]   raise_id,
    input  logic              clear_vld,
    input  logic [ID_W-1:0]   clear_id,
    input  logic              accept_req,
    output logic [PRIO_W-1:0] pend_prio,
    output logic [CODE_W-1:0] pend_code,
    output logic              accept_vld,
    output logic [CODE_W-1:0] accept_code,
    output logic              accept_err
);
    import pend_list_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SRC);

    function automatic logic [PRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
        return SRC_PRIO[int'(id)*PRIO_W +: PRIO_W];
    endfunction

    function automatic logic [CODE_W-1:0] code_of(input logic [ID_W-1:0] id);
        return SRC_CODE[int'(id)*CODE_W +: CODE_W];
    endfunction

    list_state_e                  state_q, state_nxt;
    logic [CNT_W-1:0]             fill_q, fill_nxt;
    logic [NUM_SRC-1:0][ID_W-1:0] slot_id;
    logic                         raise_dup, clear_hit;
    logic [CNT_W-1:0]             clear_idx, ins_idx;
    logic [ID_W-1:0]              top_id;
    logic                         do_ins, do_del;

    pend_scan #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W),
        .CNT_W   (CNT_W),
        .PRIO_W  (PRIO_W),
        .SRC_PRIO(SRC_PRIO)
    ) i_scan (
        .slot_id  (slot_id),
        .fill     (fill_q),
        .raise_id (raise_id),
        .clear_id (clear_id),
        .raise_dup(raise_dup),
        .clear_hit(clear_hit),
        .clear_idx(clear_idx),
        .ins_idx  (ins_idx),
        .top_id   (top_id)
    );

    // A clear wins over a raise arriving in the same cycle.
    assign do_del = clear_vld && clear_hit;
    assign do_ins = raise_vld && !clear_vld && !raise_dup && (state_q != ST_FULL);

    pend_slots #(
        .NUM_SRC(NUM_SRC),
        .ID_W   (ID_W),
        .CNT_W  (CNT_W)
    ) i_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_ins (do_ins),
        .ins_idx(ins_idx),
        .ins_id (raise_id),
        .do_del (do_del),
        .del_idx(clear_idx),
        .slot_q (slot_id)
    );

    // Next-state logic for the occupancy machine.
    always_comb begin
        state_nxt = state_q;
        fill_nxt  = fill_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (do_ins) begin
                    fill_nxt  = CNT_W'(1);
                    state_nxt = (FULL_CNT == CNT_W'(1)) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (do_del) begin
                    fill_nxt  = fill_q - CNT_W'(1);
                    state_nxt = (fill_q == CNT_W'(1)) ? ST_EMPTY : ST_PARTIAL;
                end else if (do_ins) begin
                    fill_nxt  = fill_q + CNT_W'(1);
                    state_nxt = (fill_q + CNT_W'(1) == FULL_CNT) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_FULL: begin
                if (do_del) begin
                    fill_nxt  = fill_q - CNT_W'(1);
                    state_nxt = (fill_q == CNT_W'(1)) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: begin
                state_nxt = ST_EMPTY;
                fill_nxt  = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            fill_q  <= '0;
        end else begin
            state_q <= state_nxt;
            fill_q  <= fill_nxt;
        end
    end

    // Output process: accept response is registered, top view is live.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_vld  <= 1'b0;
            accept_code <= '0;
            accept_err  <= 1'b0;
        end else begin
            accept_vld  <= accept_req;
            accept_err  <= accept_req && (state_q == ST_EMPTY);
            accept_code <= (accept_req && state_q != ST_EMPTY) ? code_of(top_id) : '0;
        end
    end

    assign pend_prio = (state_q == ST_EMPTY) ? '0 : prio_of(top_id);
    assign pend_code = (state_q == ST_EMPTY) ? '0 : code_of(top_id);

    // Input assumptions: identifiers are in range whenever their strobes are high.
    AST_RAISE_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        raise_vld |-> (int'(raise_id) < NUM_SRC));                                  // R2
    AST_CLEAR_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_vld |-> (int'(clear_id) < NUM_SRC));                                  // R5

    AST_EMPTY_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (fill_q == '0));                                   // R1
    AST_FULL_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == (fill_q == FULL_CNT));                              // R2

    for (genvar p = 0; p + 1 < NUM_SRC; p++) begin : g_order_chk
        AST_SORTED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            (CNT_W'(p + 1) < fill_q) |->
                (prio_of(slot_id[p]) <= prio_of(slot_id[p+1])));                    // R2
    end

    AST_DUP_KEEPS_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && raise_dup && !clear_vld) |=> $stable(slot_id) && $stable(fill_q)); // R4
    AST_CLEAR_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_vld && clear_hit) |=> (fill_q == $past(fill_q) - CNT_W'(1)));        // R5
    AST_ABSENT_CLEAR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_vld && !clear_hit) |=> $stable(slot_id) && $stable(fill_q));         // R6
    AST_ACCEPT_KEEPS_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_req && !raise_vld && !clear_vld) |=> $stable(fill_q));              // R7
    AST_ERR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        accept_err |-> (accept_vld && accept_code == '0));                          // R8
    AST_RAISE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && clear_vld && !clear_hit) |=> $stable(fill_q));                // R9

endmodule

// File: tb/test_pend_list.sv
module test_pend_list;

    localparam int NSRC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_vld = 1'b0;
    logic [2:0]  raise_id = '0;
    logic        clear_vld = 1'b0;
    logic [2:0]  clear_id = '0;
    logic        accept_req = 1'b0;
    logic [3:0]  pend_prio;
    logic [11:0] pend_code;
    logic        accept_vld;
    logic [11:0] accept_code;
    logic        accept_err;

    always #5 clk = ~clk;

    pend_list i_pend_list (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_vld  (raise_vld),
        .raise_id   (raise_id),
        .clear_vld  (clear_vld),
        .clear_id   (clear_id),
        .accept_req (accept_req),
        .pend_prio  (pend_prio),
        .pend_code  (pend_code),
        .accept_vld (accept_vld),
        .accept_code(accept_code),
        .accept_err (accept_err)
    );

    int checks = 0;
    int fails  = 0;
    int model_q[$];
    int exp_avld = 0, exp_acode = 0, exp_aerr = 0;
    int tb_prio[NSRC] = '{3, 7, 7, 10, 1, 15, 7, 5};

    function automatic int code_for(int id);
        return 'h200 + id * 'h20;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int ep = (model_q.size() == 0) ? 0 : tb_prio[model_q[$]];
        int ec = (model_q.size() == 0) ? 0 : code_for(model_q[$]);
        check(tag, "pend_prio", int'(pend_prio), ep);
        check(tag, "pend_code", int'(pend_code), ec);
        check(tag, "accept_vld", int'(accept_vld), exp_avld);
        check(tag, "accept_code", int'(accept_code), exp_acode);
        check(tag, "accept_err", int'(accept_err), exp_aerr);
    endtask

    function automatic void model_step(int rv, int rid, int cv, int cid);
        if (cv != 0) begin
            for (int i = model_q.size() - 1; i >= 0; i--) begin
                if (model_q[i] == cid) begin
                    model_q.delete(i);
                    break;
                end
            end
        end else if (rv != 0) begin
            int present = 0;
            int pos = 0;
            foreach (model_q[i]) if (model_q[i] == rid) present = 1;
            if (present == 0) begin
                foreach (model_q[i]) if (tb_prio[model_q[i]] <= tb_prio[rid]) pos++;
                model_q.insert(pos, rid);
            end
        end
    endfunction

    // Called at a falling edge; applies one cycle of stimulus and checks at the next falling edge.
    task automatic cyc(string tag, int rv, int rid, int cv, int cid, int av);
        int nv, nc, ne;
        raise_vld  = rv[0];
        raise_id   = rid[2:0];
        clear_vld  = cv[0];
        clear_id   = cid[2:0];
        accept_req = av[0];
        nv = av;
        ne = (av != 0 && model_q.size() == 0) ? 1 : 0;
        nc = (av != 0 && model_q.size() != 0) ? code_for(model_q[$]) : 0;
        @(posedge clk);
        #1;
        model_step(rv, rid, cv, cid);
        exp_avld = nv; exp_acode = nc; exp_aerr = ne;
        raise_vld = 1'b0; clear_vld = 1'b0; accept_req = 1'b0;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2: ordered insertion
        cyc("R2", 1, 0, 0, 0, 0);
        cyc("R2", 1, 3, 0, 0, 0);
        cyc("R2", 1, 4, 0, 0, 0);
        cyc("R2", 1, 5, 0, 0, 0);
        // R7: non-destructive accept
        cyc("R7", 0, 0, 0, 0, 1);
        cyc("R7", 0, 0, 0, 0, 1);
        cyc("R7", 0, 0, 0, 0, 0);
        // R3: equal priorities, newest on top
        cyc("R3", 1, 1, 0, 0, 0);
        cyc("R3", 1, 2, 0, 0, 0);
        cyc("R5", 0, 0, 1, 5, 0);
        cyc("R5", 0, 0, 1, 3, 1);
        cyc("R3", 0, 0, 0, 0, 1);
        // R4: duplicate raise of an older equal-priority source
        cyc("R4", 1, 1, 0, 0, 0);
        cyc("R3", 0, 0, 1, 2, 0);
        // R6: clear of an absent source
        cyc("R6", 0, 0, 1, 7, 0);
        cyc("R6", 0, 0, 1, 3, 0);
        // R5: clear from the middle
        cyc("R5", 0, 0, 1, 0, 0);
        // R9: simultaneous raise and clear
        cyc("R9", 1, 6, 1, 4, 0);
        cyc("R9", 1, 5, 1, 7, 0);
        // fill everything, then duplicate at full
        for (int s = 0; s < NSRC; s++) cyc("R2", 1, s, 0, 0, 0);
        cyc("R4", 1, 5, 0, 0, 1);
        cyc("R4", 1, 0, 0, 0, 0);
        // drain, top first and bottom first
        cyc("R5", 0, 0, 1, 5, 0);
        cyc("R5", 0, 0, 1, 4, 0);
        for (int s = 0; s < NSRC; s++) cyc("R5", 0, 0, 1, s, 0);
        // R8: accept on empty list
        cyc("R8", 0, 0, 0, 0, 1);
        cyc("R8", 0, 0, 1, 2, 1);

        // mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            string tg;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3] && lfsr[4])  tg = "R9";
            else if (lfsr[4])        tg = "R5";
            else if (lfsr[3])        tg = "R2";
            else                     tg = "R7";
            cyc(tg, int'(lfsr[3] | lfsr[9]), int'(lfsr[2:0]),
                int'(lfsr[4] & lfsr[11]), int'(lfsr[7:5]), int'(lfsr[8]));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule